// File: doc/BRIEF.md
# Space-Vector Duty Normalizer and Clamp

This block turns three signed phase voltage references in Q1.15 form into three unsigned PWM duty counts. It first centres the three references with min/max offset injection, which yields three raw space-vector timing values in Q0.15 form, together with the number of the 60-degree sector the voltage vector lies in. Each raw timing value is then rescaled to a programmable full-scale count and limited to a programmable window. The last results stay on the duty outputs until the next operation completes.

Software starts an operation with a one-cycle start pulse. The busy flag clears by itself when the result lands, and a one-cycle abort pulse (the equivalent of writing the start bit back to zero) stops the operation and returns the block to idle. A disable input keeps the whole computation off. In automatic mode, the finished duties are offered to an external PWM duty-register interface on a one-cycle load strobe, but only while that PWM unit reports that it is running and that its reload is enabled.

Top module: `svpwm_norm_clamp`

## Requirements
- R1: After synchronous reset, busy_o, done_o and pwm_load_o are 0, all three duty outputs are 0 and sector_o is 1.
- R2: For each phase x, raw_x = floor((2*v_x - vmax - vmin)/4) + 16384 (vmax and vmin are the largest and smallest of the three references), with a negative result taken as 0. The duty is floor(raw_x * full_i / 32768) before limiting. Phase a drives duty0_o, b drives duty2_o and c drives duty4_o.
- R3: The normalized duty is raised to min_i if it is below min_i and then lowered to max_i if it is above max_i, so max_i wins when min_i > max_i.
- R4: A reference counts as positive when it is zero or above. sector_o is 1 for signs (a+,b-,c-), 2 for (a+,b+,c-), 3 for (a-,b+,c-), 4 for (a-,b+,c+), 5 for (a-,b-,c+) and 6 for (a+,b-,c+). Any other pattern gives 1, so sector_o never shows 0 or 7.
- R5: A start pulse accepted at clock edge k raises busy_o after edge k. The results and a one-cycle done_o pulse appear after edge k+2, and busy_o falls at that same edge.
- R6: A start pulse while busy_o is high is ignored: it neither restarts nor queues an operation.
- R7: An abort pulse clears busy_o at the next edge. The aborted operation produces no done_o and leaves the duty outputs unchanged. Abort takes precedence over a start in the same cycle.
- R8: While disable_i is high, start pulses are ignored, and an operation in flight is dropped with no done_o and no pwm_load_o.
- R9: pwm_load_o pulses together with done_o only when auto_i, pwm_run_i and pwm_load_en_i are all 1 in the completing cycle. Otherwise it stays 0.
- R10: The duty outputs and sector_o change only in a cycle where done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request |
| abort_i | input | 1 | One-cycle abort request |
| disable_i | input | 1 | Keeps the computation off |
| auto_i | input | 1 | Automatic duty reload enable |
| pwm_run_i | input | 1 | PWM unit reports running |
| pwm_load_en_i | input | 1 | PWM unit reload enabled |
| va_i | input | 16 | Phase a reference, signed Q1.15 |
| vb_i | input | 16 | Phase b reference, signed Q1.15 |
| vc_i | input | 16 | Phase c reference, signed Q1.15 |
| full_i | input | 16 | Full-scale duty count, unsigned |
| max_i | input | 16 | Upper duty limit, unsigned |
| min_i | input | 16 | Lower duty limit, unsigned |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sector_o | output | 3 | Sector number 1 to 6 |
| duty0_o | output | 16 | Duty for phase a |
| duty2_o | output | 16 | Duty for phase b |
| duty4_o | output | 16 | Duty for phase c |
| pwm_load_o | output | 1 | Duty write and reload strobe to the PWM unit |

## Verification
The arithmetic is tried with a balanced vector, an all-zero vector, extremes at both rails, an uneven split and a maximum full-scale count. Together these separate correct offset injection, the rounding of odd sums and the rescaling from results that are off by a shift or a sign. Eight sign patterns, covering each sector plus the all-positive and all-negative cases, show whether each sign combination maps to its own sector code. Limit windows that cut both ends, and a window with min above max, show the order in which the two limits apply. Starts while busy, aborts, disable, and each of the four reload-enable combinations show that the control path gates results and strobes in the right cycles.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAW   = 2'd1,
    ST_SCALE = 2'd2
  } svp_state_t;

  localparam int NCH = 3;
endpackage

// File: rtl/svpwm_sector.sv
module svpwm_sector #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] c_i,
  output logic        [2:0]    sector_o,
  output logic signed [DW-1:0] vmax_o,
  output logic signed [DW-1:0] vmin_o
);
  logic signed [DW-1:0] hi_ab, lo_ab;

  always_comb begin
    // sign bits: 1 means negative, order {c, b, a}
    unique case ({c_i[DW-1], b_i[DW-1], a_i[DW-1]})
      3'b110:  sector_o = 3'd1;
      3'b100:  sector_o = 3'd2;
      3'b101:  sector_o = 3'd3;
      3'b001:  sector_o = 3'd4;
      3'b011:  sector_o = 3'd5;
      3'b010:  sector_o = 3'd6;
      default: sector_o = 3'd1;
    endcase
  end

  always_comb begin
    hi_ab  = (a_i > b_i) ? a_i : b_i;
    lo_ab  = (a_i < b_i) ? a_i : b_i;
    vmax_o = (hi_ab > c_i) ? hi_ab : c_i;
    vmin_o = (lo_ab < c_i) ? lo_ab : c_i;
  end
endmodule

// File: rtl/svpwm_raw.sv
module svpwm_raw #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] v_i,
  input  logic signed [DW-1:0] vmax_i,
  input  logic signed [DW-1:0] vmin_i,
  output logic        [DW-1:0] raw_o
);
  localparam int SW      = DW + 2;
  localparam int QUARTER = 1 << (DW - 2);

  logic signed [SW-1:0] diff, quart, sum;

  always_comb begin
    diff  = (SW'(v_i) <<< 1) - SW'(vmax_i) - SW'(vmin_i);
    quart = diff >>> 2;
    sum   = quart + SW'(QUARTER);
    raw_o = sum[SW-1] ? '0 : DW'(sum);
  end
endmodule

// File: rtl/svpwm_scale.sv
module svpwm_scale #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] full_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] max_i,
  output logic [DW-1:0] duty_o
);
  localparam int FRAC = DW - 1;

  logic [2*DW-1:0] prod;
  logic [DW-1:0]   norm, floor_lim;

  always_comb begin
    prod      = raw_i * full_i;
    norm      = DW'(prod >> FRAC);
    floor_lim = (norm < min_i) ? min_i : norm;
    duty_o    = (floor_lim > max_i) ? max_i : floor_lim;
  end
endmodule

// File: rtl/svpwm_norm_clamp.sv
module svpwm_norm_clamp #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          disable_i,
  input  logic          auto_i,
  input  logic          pwm_run_i,
  input  logic          pwm_load_en_i,
  input  logic [DW-1:0] va_i,
  input  logic [DW-1:0] vb_i,
  input  logic [DW-1:0] vc_i,
  input  logic [DW-1:0] full_i,
  input  logic [DW-1:0] max_i,
  input  logic [DW-1:0] min_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    sector_o,
  output logic [DW-1:0] duty0_o,
  output logic [DW-1:0] duty2_o,
  output logic [DW-1:0] duty4_o,
  output logic          pwm_load_o
);
  import svpwm_pkg::*;

  svp_state_t           state;
  logic signed [DW-1:0] v_q   [NCH];
  logic        [DW-1:0] raw_q [NCH];
  logic        [DW-1:0] raw_c [NCH];
  logic        [DW-1:0] duty_c[NCH];
  logic        [DW-1:0] duty_q[NCH];
  logic        [2:0]    sect_c, sect_q;
  logic signed [DW-1:0] vmax_c, vmin_c;

  svpwm_sector #(.DW(DW)) u_sector (
    .a_i(v_q[0]), .b_i(v_q[1]), .c_i(v_q[2]),
    .sector_o(sect_c), .vmax_o(vmax_c), .vmin_o(vmin_c)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    svpwm_raw #(.DW(DW)) u_raw (
      .v_i(v_q[i]), .vmax_i(vmax_c), .vmin_i(vmin_c), .raw_o(raw_c[i])
    );
    svpwm_scale #(.DW(DW)) u_scale (
      .raw_i(raw_q[i]), .full_i(full_i), .min_i(min_i), .max_i(max_i),
      .duty_o(duty_c[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sect_q     <= 3'd1;
      sector_o   <= 3'd1;
      done_o     <= 1'b0;
      pwm_load_o <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        v_q[i]    <= '0;
        raw_q[i]  <= '0;
        duty_q[i] <= '0;
      end
    end else begin
      done_o     <= 1'b0;
      pwm_load_o <= 1'b0;
      if (abort_i || disable_i) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (start_i) begin
            v_q[0] <= va_i;
            v_q[1] <= vb_i;
            v_q[2] <= vc_i;
            state  <= ST_RAW;
          end
          ST_RAW: begin
            for (int i = 0; i < NCH; i++) raw_q[i] <= raw_c[i];
            sect_q <= sect_c;
            state  <= ST_SCALE;
          end
          ST_SCALE: begin
            for (int i = 0; i < NCH; i++) duty_q[i] <= duty_c[i];
            sector_o   <= sect_q;
            done_o     <= 1'b1;
            pwm_load_o <= auto_i & pwm_run_i & pwm_load_en_i;
            state      <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o  = (state != ST_IDLE);
  assign duty0_o = duty_q[0];
  assign duty2_o = duty_q[1];
  assign duty4_o = duty_q[2];
endmodule

// File: rtl/svpwm_norm_clamp_chk.sv
module svpwm_norm_clamp_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          abort_i,
  input logic          disable_i,
  input logic          auto_i,
  input logic          pwm_run_i,
  input logic          pwm_load_en_i,
  input logic [DW-1:0] max_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [2:0]    sector_o,
  input logic [DW-1:0] duty0_o,
  input logic [DW-1:0] duty2_o,
  input logic [DW-1:0] duty4_o,
  input logic          pwm_load_o
);
  p_clamp_max_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (duty0_o <= $past(max_i)) && (duty2_o <= $past(max_i)) && (duty4_o <= $past(max_i)));

  p_sector_range_r4: assert property (@(posedge clk) disable iff (rst)
    (sector_o != 3'd0) && (sector_o != 3'd7));

  p_done_from_busy_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o) && !busy_o);

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_abort_drop_r7: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !busy_o && !done_o);

  p_disable_off_r8: assert property (@(posedge clk) disable iff (rst)
    disable_i |=> !busy_o && !done_o && !pwm_load_o);

  p_load_gate_r9: assert property (@(posedge clk) disable iff (rst)
    pwm_load_o |-> done_o && $past(auto_i && pwm_run_i && pwm_load_en_i));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(duty0_o) && $stable(duty2_o) && $stable(duty4_o) && $stable(sector_o));
endmodule

bind svpwm_norm_clamp svpwm_norm_clamp_chk #(.DW(DW)) chk_i (.*);

// File: tb/svpwm_norm_clamp_tb_top.sv
`timescale 1ns/1ps
module svpwm_norm_clamp_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, abort_i = 0, disable_i = 0;
  logic auto_i = 0, pwm_run_i = 0, pwm_load_en_i = 0;
  logic [15:0] va_i = 0, vb_i = 0, vc_i = 0;
  logic [15:0] full_i = 16'd1000, max_i = 16'hFFFF, min_i = 16'd0;
  logic busy_o, done_o, pwm_load_o;
  logic [2:0] sector_o;
  logic [15:0] duty0_o, duty2_o, duty4_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  svpwm_norm_clamp dut_i (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_raw(int v, int a, int b, int c);
    int mx, mn, s, q, r;
    mx = (a > b) ? a : b; mx = (mx > c) ? mx : c;
    mn = (a < b) ? a : b; mn = (mn < c) ? mn : c;
    s = 2 * v - mx - mn;
    q = (s >= 0) ? s / 4 : -((-s + 3) / 4);
    r = q + 16384;
    return (r < 0) ? 0 : r;
  endfunction

  function automatic int m_duty(int v, int a, int b, int c);
    longint n;
    int d;
    n = (longint'(m_raw(v, a, b, c)) * longint'(full_i)) / 32768;
    d = int'(n);
    if (d < int'(min_i)) d = int'(min_i);
    if (d > int'(max_i)) d = int'(max_i);
    return d;
  endfunction

  function automatic int m_sector(int a, int b, int c);
    bit ap = (a >= 0), bp = (b >= 0), cp = (c >= 0);
    if (ap && !bp && !cp) return 1;
    if (ap && bp && !cp) return 2;
    if (!ap && bp && !cp) return 3;
    if (!ap && bp && cp) return 4;
    if (!ap && !bp && cp) return 5;
    if (ap && !bp && cp) return 6;
    return 1;
  endfunction

  // start at a negedge; returns at the negedge after the third rising edge
  task automatic run_op(int a, int b, int c);
    @(negedge clk);
    va_i = 16'(a); vb_i = 16'(b); vc_i = 16'(c);
    start_i = 1;
    @(negedge clk); start_i = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op_check(string req, int a, int b, int c);
    run_op(a, b, c);
    chk({req, " done"}, int'(done_o), 1);
    chk({req, " duty0"}, int'(duty0_o), m_duty(a, a, b, c));
    chk({req, " duty2"}, int'(duty2_o), m_duty(b, a, b, c));
    chk({req, " duty4"}, int'(duty4_o), m_duty(c, a, b, c));
    chk({req, " sector"}, int'(sector_o), m_sector(a, b, c));
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 load", int'(pwm_load_o), 0);
    chk("R1 duty0", int'(duty0_o), 0);
    chk("R1 duty4", int'(duty4_o), 0);
    chk("R1 sector", int'(sector_o), 1);
  endtask

  task automatic t_main;
    full_i = 16'd1000; min_i = 0; max_i = 16'hFFFF;
    op_check("R2 balanced", 16384, -8192, -8192);
    chk("R2 known duty0", int'(duty0_o), 687);
    chk("R2 known duty2", int'(duty2_o), 312);
    op_check("R2 zero", 0, 0, 0);
    op_check("R2 rails", 32767, -32768, 0);
    op_check("R2 odd", -20001, 12345, 7656);
    full_i = 16'hFFFF;
    op_check("R2 fullscale", 3, -32768, 32767);
    full_i = 16'd1000;
  endtask

  task automatic t_sectors;
    op_check("R4 s1", 10000, -5000, -5000);
    op_check("R4 s2", 5000, 5000, -10000);
    op_check("R4 s3", -5000, 10000, -5000);
    op_check("R4 s4", -10000, 5000, 5000);
    op_check("R4 s5", -5000, -5000, 10000);
    op_check("R4 s6", 5000, -10000, 5000);
    op_check("R4 allneg", -1, -1, -1);
    chk("R4 allneg code", int'(sector_o), 1);
    op_check("R4 s6 code", 5000, -10000, 5000);
    chk("R4 s6 literal", int'(sector_o), 6);
  endtask

  task automatic t_clamp;
    full_i = 16'd4000; min_i = 16'd1000; max_i = 16'd3000;
    op_check("R3 window", 30000, -30000, 0);
    chk("R3 top", int'(duty0_o), 3000);
    chk("R3 bottom", int'(duty2_o), 1000);
    chk("R3 mid", int'(duty4_o), 2000);
    min_i = 16'd3500; max_i = 16'd2500;
    op_check("R3 inverted", 30000, -30000, 0);
    chk("R3 max wins", int'(duty2_o), 2500);
    full_i = 16'd1000; min_i = 0; max_i = 16'hFFFF;
  endtask

  task automatic t_timing;
    @(negedge clk);
    va_i = 16'(1000); vb_i = 0; vc_i = 16'(-1000); start_i = 1;
    @(negedge clk); start_i = 0;
    chk("R5 busy e1", int'(busy_o), 1);
    chk("R5 done e1", int'(done_o), 0);
    @(negedge clk);
    chk("R5 busy e2", int'(busy_o), 1);
    chk("R5 done e2", int'(done_o), 0);
    @(negedge clk);
    chk("R5 done e3", int'(done_o), 1);
    chk("R5 busy e3", int'(busy_o), 0);
    @(negedge clk);
    chk("R5 done pulse", int'(done_o), 0);
  endtask

  task automatic t_restart;
    @(negedge clk);
    va_i = 16'(20000); vb_i = 16'(-10000); vc_i = 16'(-10000); start_i = 1;
    @(negedge clk);
    va_i = 16'(-20000); vb_i = 16'(10000); vc_i = 16'(10000);
    @(negedge clk); start_i = 0;
    @(negedge clk);
    chk("R6 done on time", int'(done_o), 1);
    chk("R6 first inputs", int'(duty0_o), m_duty(20000, 20000, -10000, -10000));
    @(negedge clk);
    chk("R6 no restart", int'(busy_o), 0);
    @(negedge clk); @(negedge clk);
    chk("R6 no second done", int'(done_o), 0);
  endtask

  task automatic t_abort;
    int d0, seen;
    run_op(8000, -4000, -4000);
    d0 = int'(duty0_o);
    @(negedge clk);
    va_i = 16'(-30000); vb_i = 16'(15000); vc_i = 16'(15000); start_i = 1;
    @(negedge clk); start_i = 0; abort_i = 1;
    @(negedge clk); abort_i = 0;
    chk("R7 busy cleared", int'(busy_o), 0);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
    chk("R7 no done", seen, 0);
    chk("R7 duty kept", int'(duty0_o), d0);
    @(negedge clk); start_i = 1; abort_i = 1;
    @(negedge clk); start_i = 0; abort_i = 0;
    chk("R7 abort beats start", int'(busy_o), 0);
  endtask

  task automatic t_disable;
    int d0, seen;
    d0 = int'(duty0_o);
    auto_i = 1; pwm_run_i = 1; pwm_load_en_i = 1;
    @(negedge clk); disable_i = 1;
    va_i = 16'(25000); vb_i = 16'(-25000); vc_i = 0; start_i = 1;
    @(negedge clk); start_i = 0;
    chk("R8 start ignored", int'(busy_o), 0);
    seen = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (done_o || pwm_load_o) seen = 1;
    end
    chk("R8 no done", seen, 0);
    chk("R8 duty kept", int'(duty0_o), d0);
    disable_i = 0;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0; disable_i = 1;
    @(negedge clk); disable_i = 0;
    chk("R8 dropped", int'(busy_o), 0);
    seen = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (done_o || pwm_load_o) seen = 1;
    end
    chk("R8 dropped no done", seen, 0);
    auto_i = 0; pwm_run_i = 0; pwm_load_en_i = 0;
  endtask

  task automatic t_auto;
    auto_i = 1; pwm_run_i = 1; pwm_load_en_i = 1;
    run_op(1000, 2000, -3000);
    chk("R9 load all on", int'(pwm_load_o), 1);
    @(negedge clk);
    chk("R9 load pulse", int'(pwm_load_o), 0);
    pwm_run_i = 0;
    run_op(1000, 2000, -3000);
    chk("R9 no run", int'(pwm_load_o), 0);
    pwm_run_i = 1; pwm_load_en_i = 0;
    run_op(1000, 2000, -3000);
    chk("R9 no load enable", int'(pwm_load_o), 0);
    pwm_load_en_i = 1; auto_i = 0;
    run_op(1000, 2000, -3000);
    chk("R9 manual mode", int'(pwm_load_o), 0);
    pwm_run_i = 0; pwm_load_en_i = 0;
  endtask

  task automatic t_hold;
    int d0, d2, s, moved;
    run_op(-12000, 3000, 9000);
    d0 = int'(duty0_o); d2 = int'(duty2_o); s = int'(sector_o);
    moved = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      va_i = 16'(i * 7000); full_i = 16'(i * 300 + 50); max_i = 16'(i);
      if (int'(duty0_o) != d0 || int'(duty2_o) != d2 || int'(sector_o) != s) moved = 1;
    end
    chk("R10 outputs hold", moved, 0);
    full_i = 16'd1000; max_i = 16'hFFFF;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_main();
    t_sectors();
    t_clamp();
    t_timing();
    t_restart();
    t_abort();
    t_disable();
    t_auto();
    t_hold();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule